// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for every access of a short wrapping burst into a synchronous memory array. A load cycle takes a full external address and the access direction. Each following advance cycle steps only the low offset bits, in one of two orders chosen by a static mode input. Those orders are a wrapping increment, or the starting offset XOR-ed with a running beat count. The upper address bits stay put for the whole burst.

A memory controller sits next to it and supplies the array and the data path. It reads the word address, the latched direction and the burst-active flag from registered state. A stall input freezes every register for as long as it is held. A load cycle with the chip deselected stops any burst in progress. A load cycle with the chip selected replaces the current burst at once, with no gap cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: A cycle with stall_i=0, step_i=0 and chip_sel_i=1 captures addr_i. From the next cycle word_addr_o equals that address, burst_active_o is 1 and op_write_o equals the wr_i sampled on that cycle (1 = write, 0 = read).
- R2: On an advance cycle (stall_i=0, step_i=1) addr_i is ignored.
- R3: During a burst only the low BEAT_W bits of word_addr_o change. The upper bits keep the loaded value.
- R4: With interleave_i=1, the low bits after k advances equal the starting offset XOR (k mod 4). For example, a start of 01 gives 01, 00, 11, 10.
- R5: With interleave_i=0, the low bits after k advances equal (starting offset + k) mod 4. For example, a start of 10 gives 10, 11, 00, 01.
- R6: After the fourth word the sequence returns to the starting offset and keeps cycling while advances continue.
- R7: wr_i is ignored on advance cycles. op_write_o keeps the value latched at the load.
- R8: A cycle with stall_i=0, step_i=0 and chip_sel_i=0 clears burst_active_o on the next cycle and does not change word_addr_o.
- R9: While stall_i=1, word_addr_o, op_write_o and burst_active_o hold their values whatever the other inputs do.
- R10: An advance cycle with burst_active_o=0 leaves burst_active_o at 0 and word_addr_o unchanged.
- R11: A load during a burst takes effect on the very next cycle, and the new burst sequences from its own start.
- R12: After reset, burst_active_o=0, op_write_o=0 and word_addr_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | 1 freezes all state for this edge |
| step_i | input | 1 | 1 = advance burst, 0 = load or deselect |
| chip_sel_i | input | 1 | 1 = chip selected on a load cycle |
| wr_i | input | 1 | Access direction on load, 1 = write |
| addr_i | input | ADDR_W | External word address |
| interleave_i | input | 1 | Static order select, 1 = XOR order, 0 = linear |
| word_addr_o | output | ADDR_W | Current array word address |
| op_write_o | output | 1 | Latched direction, 1 = write |
| burst_active_o | output | 1 | A burst is in progress |

## Verification
The hardest case to reach is a stall that lands in the middle of a burst while the other inputs ask for a load, a deselect or a direction flip. A correct design must ignore all of them and then carry on from the exact beat where it stopped. The stimulus builds a partial burst, holds stall with conflicting inputs for several cycles, and then checks that the next advance lands on the following beat of the order. Every starting offset in both orders is also swept through more than two full wraps with three different upper address values. wr_i and addr_i are scrambled on every advance cycle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } bsq_op_e;
endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stall_i,
  input  logic    step_i,
  input  logic    chip_sel_i,
  input  logic    wr_i,
  output logic    load_en_o,
  output logic    adv_en_o,
  output logic    active_o,
  output bsq_op_e op_o
);
  logic kill;

  assign load_en_o = !stall_i && !step_i && chip_sel_i;
  assign kill      = !stall_i && !step_i && !chip_sel_i;
  assign adv_en_o  = !stall_i && step_i && active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      op_o     <= OP_READ;
    end else if (load_en_o) begin
      active_o <= 1'b1;
      op_o     <= wr_i ? OP_WRITE : OP_READ;
    end else if (kill) begin
      active_o <= 1'b0;
    end
  end

  AST_ADV_KEEPS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !stall_i) |=> $stable(op_o)); // R7
endmodule

// File: rtl/bsq_beat_cnt.sv
module bsq_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (clear_i) beat_o <= '0;
    else if (inc_i)   beat_o <= beat_o + 1'b1;
  end

  AST_BEAT_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clear_i) |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1))); // R6
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end
endmodule

// File: rtl/bsq_order.sv
module bsq_order #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              interleave_i,
  output logic [BEAT_W-1:0] offset_o
);
  logic [BEAT_W-1:0] lin, ilv;

  assign lin = start_i + beat_i;
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign ilv[b] = start_i[b] ^ beat_i[b];
  end
  assign offset_o = interleave_i ? ilv : lin;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              step_i,
  input  logic              chip_sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              op_write_o,
  output logic              burst_active_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              load_en, adv_en, active;
  bsq_op_e           op;
  logic [BEAT_W-1:0] beat, offset;
  logic [ADDR_W-1:0] base;

  bsq_ctrl i_ctrl (
    .clk_i, .rst_ni, .stall_i, .step_i, .chip_sel_i, .wr_i,
    .load_en_o(load_en), .adv_en_o(adv_en), .active_o(active), .op_o(op)
  );

  bsq_beat_cnt #(.BEAT_W(BEAT_W)) i_beat (
    .clk_i, .rst_ni, .clear_i(load_en), .inc_i(adv_en), .beat_o(beat)
  );

  bsq_base_reg #(.ADDR_W(ADDR_W)) i_base (
    .clk_i, .rst_ni, .load_i(load_en), .addr_i, .base_o(base)
  );

  bsq_order #(.BEAT_W(BEAT_W)) i_order (
    .start_i(base[BEAT_W-1:0]), .beat_i(beat), .interleave_i, .offset_o(offset)
  );

  assign word_addr_o    = {base[ADDR_W-1:BEAT_W], offset};
  assign op_write_o     = (op == OP_WRITE);
  assign burst_active_o = active;

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !step_i && chip_sel_i) |=> (word_addr_o == $past(addr_i)) && burst_active_o); // R1
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !stall_i) |=> $stable(word_addr_o[ADDR_W-1:ADDR_W-UPPER_W])); // R3
  AST_DESEL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !step_i && !chip_sel_i) |=> !burst_active_o); // R8
  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(burst_active_o) && $stable(op_write_o)
                && (!$stable(interleave_i) || $stable(word_addr_o))); // R9
  AST_IDLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_active_o && step_i) |=> !burst_active_o && $stable(word_addr_o[ADDR_W-1:ADDR_W-UPPER_W])); // R10
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 17;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0, step = 1'b1, sel = 1'b0, wr = 1'b0, ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] waddr;
  logic          opw, act;
  int            checks = 0, fails = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .step_i(step), .chip_sel_i(sel),
    .wr_i(wr), .addr_i(addr), .interleave_i(ilv),
    .word_addr_o(waddr), .op_write_o(opw), .burst_active_o(act)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic s_stall, input logic s_step, input logic s_sel,
                     input logic s_wr, input logic [AW-1:0] s_addr);
    @(negedge clk);
    stall = s_stall; step = s_step; sel = s_sel; wr = s_wr; addr = s_addr;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [BW-1:0] exp_off(input logic m, input logic [BW-1:0] s, input int k);
    return m ? (s ^ BW'(k)) : BW'(s + BW'(k));
  endfunction

  initial begin
    #10000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-BW-1:0] up [3];
    logic [AW-1:0] a0, a1;
    up[0] = '0; up[1] = 15'h2AAA; up[2] = '1;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12 active", 32'(act), 0);
    chk("R12 op", 32'(opw), 0);
    chk("R12 addr", 32'(waddr), 0);
    @(negedge clk) rst_n = 1'b1;

    // R10 advance with no burst
    cyc(0, 1, 1, 1, 17'h1ABCD);
    chk("R10 active", 32'(act), 0);
    chk("R10 addr", 32'(waddr), 0);

    // R1..R7 sweep
    for (int m = 0; m < 2; m++) begin
      for (int u = 0; u < 3; u++) begin
        for (int s = 0; s < 4; s++) begin
          logic w;
          w = logic'((s + u) & 1);
          ilv = logic'(m);
          a0 = {up[u], BW'(s)};
          cyc(0, 0, 1, w, a0);
          chk("R1 addr", 32'(waddr), 32'(a0));
          chk("R1 active", 32'(act), 1);
          chk("R1 op", 32'(opw), 32'(w));
          for (int k = 1; k < 10; k++) begin
            cyc(0, 1, logic'(k & 1), ~w, AW'($urandom));
            chk(m ? "R4 R6 R2 R3 ilv addr" : "R5 R6 R2 R3 lin addr",
                32'(waddr), 32'({up[u], exp_off(logic'(m), BW'(s), k)}));
            chk("R7 op", 32'(opw), 32'(w));
          end
        end
      end
    end

    // R9 stall mid burst with conflicting inputs
    ilv = 1'b0;
    a0 = 17'h0F0F1;
    cyc(0, 0, 1, 1, a0);
    cyc(0, 1, 1, 0, '0);
    chk("R9 pre", 32'(waddr), 32'(17'h0F0F2));
    cyc(1, 0, 1, 0, 17'h12345);
    chk("R9 load ignored", 32'(waddr), 32'(17'h0F0F2));
    cyc(1, 0, 0, 0, 17'h00000);
    chk("R9 desel ignored", 32'(act), 1);
    cyc(1, 1, 1, 0, 17'h00000);
    chk("R9 addr held", 32'(waddr), 32'(17'h0F0F2));
    chk("R9 op held", 32'(opw), 1);
    cyc(0, 1, 1, 0, '0);
    chk("R9 resume", 32'(waddr), 32'(17'h0F0F3));

    // R11 reload mid burst
    ilv = 1'b1;
    a1 = 17'h1C3D2;
    cyc(0, 0, 1, 0, a1);
    chk("R11 new addr", 32'(waddr), 32'(a1));
    chk("R11 new op", 32'(opw), 0);
    cyc(0, 1, 1, 1, '0);
    chk("R11 next", 32'(waddr), 32'(17'h1C3D3));

    // R8 deselect ends burst, R10 afterwards
    cyc(0, 0, 0, 1, 17'h00007);
    chk("R8 active", 32'(act), 0);
    chk("R8 addr", 32'(waddr), 32'(17'h1C3D3));
    cyc(0, 1, 1, 1, 17'h00007);
    chk("R10 after desel active", 32'(act), 0);
    chk("R10 after desel addr", 32'(waddr), 32'(17'h1C3D3));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule